// File: doc/BRIEF.md
# Multi-Source Limit Alert Monitor

This block takes four measurements from a power monitor: shunt voltage, bus voltage, die temperature and power. Each one arrives as both a raw sample and an averaged sample, and a one-cycle strobe marks each finished conversion. On that strobe the block runs six limit checks against thresholds that software can program. It records the results in a diagnostic status word and drives a single open-drain style alert output.

The alert output can also signal conversion-ready events. A control bit makes the limit flags sticky until the status word is read. Another control bit chooses between raw and averaged samples for the comparisons. A polarity bit selects whether the alert is active-low or active-high. Two more status flags, math overflow and memory health, are visible through the register port but never drive the alert.

The register port is a simple synchronous bus. Writes take effect at the clock edge. Read data is combinational from the address. A read of the status word with `reg_rd` high is the event that clears sticky state.

Top module: `limit_alert_monitor`

## Requirements
- R1: Six limit checks share one status word at address 1. Each check has its own flag: bit0 shunt-under, bit1 shunt-over, bit2 bus-over, bit3 bus-under, bit4 temperature-over, bit5 power-over. The matching thresholds are at addresses 2 to 7 in that same order.
- R2: After reset the control word (address 0) reads 0. The thresholds read shunt-under 0x8000, shunt-over 0x7FFF, bus-over 0x7FFF, bus-under 0x0000, temperature 0xFFFF and power 0x7FFF.
- R3: Shunt-under, shunt-over, bus-under and power-over compare two's-complement 16-bit values. Over means the sample is strictly greater than the threshold. Under means the sample is strictly less than the threshold.
- R4: Bus-over and temperature-over trip only when the sample is non-negative and its value is strictly greater than the threshold read as unsigned. A negative sample never trips them.
- R5: Comparisons occur only on a cycle with `conv_done` high. With latching off (control bit0 = 0), each limit flag holds the result of the latest comparison.
- R6: With latching on (control bit0 = 1), a set limit flag stays set until the status word is read. The read clears all limit flags together, so the alert stays asserted after the conditions clear.
- R7: Status bit6 is set on every conversion, whatever the value of control bit1, and a status read clears it. A conversion in the same cycle as the read wins.
- R8: With control bit1 set, a set status bit6 also asserts the alert.
- R9: With control bit2 set, the comparisons use the averaged samples instead of the raw ones.
- R10: `alert_pull_low` is 1 exactly when the pin should be driven low. With control bit3 = 0 (active-low) that is when the alert is active. With bit3 = 1 (active-high) that is when the alert is inactive.
- R11: Status bit7 reflects `math_ovf_in` and status bit8 reflects `mem_ok_in`. Neither affects `alert_pull_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| raw_shunt | input | 16 | Raw shunt voltage sample, signed |
| raw_bus | input | 16 | Raw bus voltage sample, signed |
| raw_temp | input | 16 | Raw temperature sample, signed |
| raw_power | input | 16 | Raw power sample, signed |
| avg_shunt | input | 16 | Averaged shunt voltage sample |
| avg_bus | input | 16 | Averaged bus voltage sample |
| avg_temp | input | 16 | Averaged temperature sample |
| avg_power | input | 16 | Averaged power sample |
| math_ovf_in | input | 1 | Arithmetic overflow indication from the datapath |
| mem_ok_in | input | 1 | Trim memory health indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| alert_pull_low | output | 1 | Open-drain drive-low enable for the alert pin |

## Verification
The bench sweeps every pair of eight corner values (0x0000, 0x0001, 0x4000, 0x7FFE, 0x7FFF, 0x8000, 0x8001, 0xFFFF), used both as samples and as thresholds, over all six checks. A design that compared unsigned where it should compare signed, used greater-or-equal where it should use strict, or let a negative bus or temperature sample trip an over-limit would flip status bits at the 0x7FFF/0x8000 boundary or at equal values. Latching is checked by removing the condition and confirming the alert holds until a status read. A design that cleared on any read, or never cleared, shows up there. Separate cases show that conversion-ready events reach the pin only when enabled, that averaged samples replace raw ones, that polarity inverts the drive, and that the overflow and memory flags leave the pin alone.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam int DW     = 16;
    localparam int NLIM   = 6;
    localparam int AW     = 4;

    // limit indices: also the status bit positions
    localparam int L_SHUNT_UNDER = 0;
    localparam int L_SHUNT_OVER  = 1;
    localparam int L_BUS_OVER    = 2;
    localparam int L_BUS_UNDER   = 3;
    localparam int L_TEMP_OVER   = 4;
    localparam int L_POWER_OVER  = 5;

    localparam int ST_CONV = NLIM;
    localparam int ST_MATH = NLIM + 1;
    localparam int ST_MEM  = NLIM + 2;

    typedef enum logic [AW-1:0] {
        A_CTRL   = 4'd0,
        A_STATUS = 4'd1,
        A_LIM0   = 4'd2
    } addr_e;

    typedef enum logic [1:0] {
        K_SIGNED_OVER,
        K_SIGNED_UNDER,
        K_NONNEG_OVER
    } cmp_kind_e;

    typedef struct packed {
        logic pol_high;
        logic slow_sel;
        logic cnvr_en;
        logic latch_en;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0] shunt;
        logic [DW-1:0] bus;
        logic [DW-1:0] temp;
        logic [DW-1:0] power;
    } sample_set_t;

    function automatic logic [DW-1:0] lim_default(input int idx);
        case (idx)
            L_SHUNT_UNDER: return 16'h8000;
            L_BUS_UNDER:   return 16'h0000;
            L_TEMP_OVER:   return 16'hFFFF;
            default:       return 16'h7FFF;
        endcase
    endfunction

    function automatic cmp_kind_e lim_kind(input int idx);
        case (idx)
            L_SHUNT_UNDER, L_BUS_UNDER: return K_SIGNED_UNDER;
            L_BUS_OVER, L_TEMP_OVER:    return K_NONNEG_OVER;
            default:                    return K_SIGNED_OVER;
        endcase
    endfunction

    function automatic logic cmp_eval(input cmp_kind_e k,
                                      input logic [DW-1:0] s,
                                      input logic [DW-1:0] t);
        case (k)
            K_SIGNED_OVER:  return $signed(s) > $signed(t);
            K_SIGNED_UNDER: return $signed(s) < $signed(t);
            default:        return (s[DW-1] == 1'b0) && (s > t);
        endcase
    endfunction

endpackage

// File: rtl/lam_regfile.sv
module lam_regfile
    import lam_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [AW-1:0]            reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output ctrl_t                    ctrl,
    output logic [NLIM-1:0][DW-1:0]  thr
);
    localparam int CW = $bits(ctrl_t);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (reg_wr && reg_addr == A_CTRL)
            ctrl <= ctrl_t'(reg_wdata[CW-1:0]);
    end

    for (genvar i = 0; i < NLIM; i++) begin : g_thr
        localparam logic [AW-1:0] MY_ADDR = AW'(int'(A_LIM0) + i);
        always_ff @(posedge clk) begin
            if (rst)
                thr[i] <= lim_default(i);
            else if (reg_wr && reg_addr == MY_ADDR)
                thr[i] <= reg_wdata;
        end
    end
endmodule

// File: rtl/lam_compare.sv
module lam_compare
    import lam_pkg::*;
(
    input  sample_set_t              smp,
    input  logic [NLIM-1:0][DW-1:0]  thr,
    output logic [NLIM-1:0]          trip
);
    for (genvar i = 0; i < NLIM; i++) begin : g_cmp
        logic [DW-1:0] s;
        always_comb begin
            case (i)
                L_SHUNT_UNDER, L_SHUNT_OVER: s = smp.shunt;
                L_BUS_OVER, L_BUS_UNDER:     s = smp.bus;
                L_TEMP_OVER:                 s = smp.temp;
                default:                     s = smp.power;
            endcase
        end
        assign trip[i] = cmp_eval(lim_kind(i), s, thr[i]);
    end
endmodule

// File: rtl/lam_status.sv
module lam_status
    import lam_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [NLIM-1:0]  trip,
    input  ctrl_t            ctrl,
    input  logic             status_rd,
    output logic [NLIM-1:0]  flag_vec,
    output logic             conv_flag,
    output logic             alert_int,
    output logic             alert_pull_low
);
    logic [NLIM-1:0] kept;

    always_comb begin
        kept = (status_rd ? '0 : flag_vec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_vec <= '0;
        end else if (ctrl.latch_en) begin
            flag_vec <= kept | (conv_done ? trip : '0);
        end else if (conv_done) begin
            flag_vec <= trip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            conv_flag <= 1'b0;
        else if (conv_done)
            conv_flag <= 1'b1;
        else if (status_rd)
            conv_flag <= 1'b0;
    end

    assign alert_int      = (|flag_vec) | (ctrl.cnvr_en & conv_flag);
    assign alert_pull_low = alert_int ^ ctrl.pol_high;
endmodule

// File: rtl/limit_alert_monitor.sv
module limit_alert_monitor
    import lam_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            conv_done,
    input  logic [15:0]     raw_shunt,
    input  logic [15:0]     raw_bus,
    input  logic [15:0]     raw_temp,
    input  logic [15:0]     raw_power,
    input  logic [15:0]     avg_shunt,
    input  logic [15:0]     avg_bus,
    input  logic [15:0]     avg_temp,
    input  logic [15:0]     avg_power,
    input  logic            math_ovf_in,
    input  logic            mem_ok_in,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [3:0]      reg_addr,
    input  logic [15:0]     reg_wdata,
    output logic [15:0]     reg_rdata,
    output logic            alert_pull_low
);
    ctrl_t                   ctrl;
    logic [NLIM-1:0][DW-1:0] thr;
    sample_set_t             raw_set, avg_set, sel_set;
    logic [NLIM-1:0]         trip;
    logic [NLIM-1:0]         flag_vec;
    logic                    conv_flag;
    logic                    alert_int;
    logic                    status_rd;

    assign raw_set = '{shunt: raw_shunt, bus: raw_bus, temp: raw_temp, power: raw_power};
    assign avg_set = '{shunt: avg_shunt, bus: avg_bus, temp: avg_temp, power: avg_power};
    assign sel_set = ctrl.slow_sel ? avg_set : raw_set;
    assign status_rd = reg_rd && (reg_addr == A_STATUS);

    lam_regfile u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ctrl(ctrl), .thr(thr)
    );

    lam_compare u_cmp (.smp(sel_set), .thr(thr), .trip(trip));

    lam_status u_stat (
        .clk(clk), .rst(rst), .conv_done(conv_done), .trip(trip),
        .ctrl(ctrl), .status_rd(status_rd), .flag_vec(flag_vec),
        .conv_flag(conv_flag), .alert_int(alert_int),
        .alert_pull_low(alert_pull_low)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[$bits(ctrl_t)-1:0] = ctrl;
        end else if (reg_addr == A_STATUS) begin
            reg_rdata[NLIM-1:0] = flag_vec;
            reg_rdata[ST_CONV]  = conv_flag;
            reg_rdata[ST_MATH]  = math_ovf_in;
            reg_rdata[ST_MEM]   = mem_ok_in;
        end else begin
            for (int i = 0; i < NLIM; i++)
                if (reg_addr == AW'(int'(A_LIM0) + i))
                    reg_rdata = thr[i];
        end
    end
endmodule

// File: rtl/lam_checker.sv
module lam_checker (
    input logic       clk,
    input logic       rst,
    input logic       conv_done,
    input logic       status_rd,
    input logic [3:0] ctrl,
    input logic [5:0] flag_vec,
    input logic       conv_flag,
    input logic       math_ovf_in,
    input logic       mem_ok_in,
    input logic       alert_pull_low
);
    // R5: without a strobe or a status read the limit flags do not move
    a_r5_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !status_rd) |=> $stable(flag_vec));

    // R6: sticky flags keep every set bit until a status read
    a_r6_latch_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl[0] && !status_rd) |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

    // R6: a status read in latch mode without a strobe empties the flags
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (ctrl[0] && status_rd && !conv_done) |=> (flag_vec == 6'd0));

    // R7: every conversion leaves the conversion flag set
    a_r7_conv_flag_set: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> conv_flag);

    // R11: the status-only inputs never move the alert pin on their own
    a_r11_status_only: assert property (@(posedge clk) disable iff (rst)
        ($stable(flag_vec) && $stable(conv_flag) && $stable(ctrl)
         && (!$stable(math_ovf_in) || !$stable(mem_ok_in))) |-> $stable(alert_pull_low));
endmodule

bind limit_alert_monitor lam_checker u_lam_checker (
    .clk(clk), .rst(rst), .conv_done(conv_done), .status_rd(status_rd),
    .ctrl(ctrl), .flag_vec(flag_vec), .conv_flag(conv_flag),
    .math_ovf_in(math_ovf_in), .mem_ok_in(mem_ok_in),
    .alert_pull_low(alert_pull_low)
);

// File: tb/limit_alert_monitor_tb.sv
module limit_alert_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [15:0] raw_shunt = '0, raw_bus = '0, raw_temp = '0, raw_power = '0;
    logic [15:0] avg_shunt = '0, avg_bus = '0, avg_temp = '0, avg_power = '0;
    logic        math_ovf_in = 1'b0, mem_ok_in = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        alert_pull_low;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    limit_alert_monitor dut_i (
        .clk(clk), .rst(rst), .conv_done(conv_done),
        .raw_shunt(raw_shunt), .raw_bus(raw_bus), .raw_temp(raw_temp), .raw_power(raw_power),
        .avg_shunt(avg_shunt), .avg_bus(avg_bus), .avg_temp(avg_temp), .avg_power(avg_power),
        .math_ovf_in(math_ovf_in), .mem_ok_in(mem_ok_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alert_pull_low(alert_pull_low)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // peek: read without side effects
    task automatic peek(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // status read with the clearing side effect
    task automatic rd_status(output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'd1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_raw(input logic [15:0] v);
        raw_shunt = v; raw_bus = v; raw_temp = v; raw_power = v;
    endtask

    task automatic set_avg(input logic [15:0] v);
        avg_shunt = v; avg_bus = v; avg_temp = v; avg_power = v;
    endtask

    task automatic pulse_conv();
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Independent arithmetic model of one limit check (R3, R4)
    function automatic bit exp_trip(input int k, input logic [15:0] s, input logic [15:0] t);
        int ss, ts, tu;
        ss = s[15] ? int'({16'd0, s}) - 65536 : int'({16'd0, s});
        ts = t[15] ? int'({16'd0, t}) - 65536 : int'({16'd0, t});
        tu = int'({16'd0, t});
        case (k)
            0, 3:    return ss < ts;
            2, 4:    return (ss >= 0) && (ss > tu);
            default: return ss > ts;
        endcase
    endfunction

    initial begin
        #200000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] corner [8];
        logic [15:0] dflt [6];
        corner = '{16'h0000, 16'h0001, 16'h4000, 16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
        dflt   = '{16'h8000, 16'h7FFF, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h7FFF};

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2: reset state
        peek(4'd0, d); check("R2 ctrl reset", d, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            peek(4'(i + 2), d); check("R2 threshold reset", d, dflt[i]);
        end
        peek(4'd1, d); check("R11 status reset mem flag", d, 16'h0100);
        check("R10 pin idle after reset", {15'd0, alert_pull_low}, 16'h0000);

        // R1 R3 R4 R5: sweep of all sample/threshold corner pairs, latch off
        for (int ti = 0; ti < 8; ti++) begin
            for (int k = 0; k < 6; k++) wr(4'(k + 2), corner[ti]);
            for (int si = 0; si < 8; si++) begin
                logic [5:0] e;
                set_raw(corner[si]);
                pulse_conv();
                for (int k = 0; k < 6; k++) e[k] = exp_trip(k, corner[si], corner[ti]);
                peek(4'd1, d);
                check("R1 R3 R4 R5 sweep flags", {10'd0, d[5:0]}, {10'd0, e});
                check("R10 active-low pin", {15'd0, alert_pull_low}, {15'd0, |e});
            end
        end

        // R5: samples change with no strobe: flags stay
        wr(4'd2, 16'h8000); wr(4'd3, 16'h7FFF); wr(4'd4, 16'h7FFF);
        wr(4'd5, 16'h0000); wr(4'd6, 16'hFFFF); wr(4'd7, 16'h7FFF);
        set_raw(16'h0010); pulse_conv();
        rd_status(d);
        check("R5 clean conversion", {10'd0, d[5:0]}, 16'h0000);
        wr(4'd3, 16'h0005);
        set_raw(16'h0020);
        repeat (3) @(negedge clk);
        peek(4'd1, d); check("R5 no compare without strobe", {10'd0, d[5:0]}, 16'h0000);
        pulse_conv();
        peek(4'd1, d); check("R5 compare on strobe", {10'd0, d[5:0]}, 16'h0002);
        set_raw(16'h0001); pulse_conv();
        peek(4'd1, d); check("R5 tracking clears", {10'd0, d[5:0]}, 16'h0000);

        // R6: latch mode
        wr(4'd0, 16'h0001);
        set_raw(16'h0020); pulse_conv();
        set_raw(16'h0001); pulse_conv(); pulse_conv();
        peek(4'd1, d); check("R6 sticky flag", {10'd0, d[5:0]}, 16'h0002);
        check("R6 pin held", {15'd0, alert_pull_low}, 16'h0001);
        wr(4'd2, 16'h0000); wr(4'd3, 16'h0005);
        peek(4'd1, d); check("R6 non-status access keeps flag", {10'd0, d[5:0]}, 16'h0002);
        rd_status(d);
        check("R6 read returns flag", {10'd0, d[5:0]}, 16'h0002);
        peek(4'd1, d); check("R6 read clears", {10'd0, d[5:0]}, 16'h0000);
        check("R6 pin released", {15'd0, alert_pull_low}, 16'h0000);
        wr(4'd2, 16'h8000);

        // R7 R8: conversion-ready signalling
        wr(4'd0, 16'h0000);
        rd_status(d);
        pulse_conv();
        peek(4'd1, d); check("R7 conv flag without enable", {15'd0, d[6]}, 16'h0001);
        check("R8 no pin without enable", {15'd0, alert_pull_low}, 16'h0000);
        wr(4'd0, 16'h0002);
        check("R8 pin with enable", {15'd0, alert_pull_low}, 16'h0001);
        rd_status(d);
        peek(4'd1, d); check("R7 read clears conv flag", {15'd0, d[6]}, 16'h0000);
        check("R8 pin drops after read", {15'd0, alert_pull_low}, 16'h0000);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'd1; conv_done = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; conv_done = 1'b0;
        peek(4'd1, d); check("R7 conversion wins over read", {15'd0, d[6]}, 16'h0001);
        wr(4'd0, 16'h0000); rd_status(d);

        // R9: averaged comparison
        set_raw(16'h0020); set_avg(16'h0001);
        wr(4'd0, 16'h0004); pulse_conv();
        peek(4'd1, d); check("R9 averaged used", {10'd0, d[5:0]}, 16'h0000);
        wr(4'd0, 16'h0000); pulse_conv();
        peek(4'd1, d); check("R9 raw used", {10'd0, d[5:0]}, 16'h0002);
        set_avg(16'h0030); wr(4'd0, 16'h0004); pulse_conv();
        peek(4'd1, d); check("R9 averaged trips", {10'd0, d[5:0]}, 16'h0002);

        // R10: active-high polarity
        wr(4'd0, 16'h000C);
        check("R10 active-high asserted releases pin", {15'd0, alert_pull_low}, 16'h0000);
        set_avg(16'h0001); pulse_conv(); rd_status(d);
        check("R10 active-high idle pulls low", {15'd0, alert_pull_low}, 16'h0001);

        // R11: status-only flags
        math_ovf_in = 1'b1; mem_ok_in = 1'b0;
        peek(4'd1, d);
        check("R11 status-only flags read", {14'd0, d[8:7]}, 16'h0001);
        check("R11 pin unaffected", {15'd0, alert_pull_low}, 16'h0001);
        wr(4'd0, 16'h0000);
        check("R11 pin unaffected active-low", {15'd0, alert_pull_low}, 16'h0000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule